// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits between a group of sixteen request lanes and a scratchpad made of sixteen single-ported banks of 32-bit words. One request carries a read or write opcode shared by all lanes. Each lane has its own enable bit, word address and write word. The block latches the request and works out which bank each lane hits. It then runs as few bank cycles as the bank collisions allow, with each bank doing at most one access per cycle.

There is one special case. When the request is a read and every enabled lane names the same word, the word is fanned out to all of those lanes in a single cycle. While a request is in flight the block reports busy and refuses new requests. When the last access finishes it raises a one-cycle done pulse, and the per-lane read words stay stable from then on. A free-running counter adds up the extra cycles caused by bank collisions, for profiling. The bank storage is part of the block.

Top module: `sp_conflict_arb`

## Requirements
- R1: A word address selects bank `addr[3:0]` and row `addr[9:4]` inside that bank, so two enabled lanes collide exactly when their addresses agree in the low four bits.
- R2: A request whose enabled lanes all hit different banks keeps busy_o high for exactly one cycle.
- R3: Otherwise busy_o stays high for as many cycles as the largest number of enabled lanes that hit any single bank.
- R4: A read in which every enabled lane names the same address takes one cycle, and each enabled lane receives that word.
- R5: Lanes that collide on a bank are served in ascending lane order. When several lanes of one write name the same address, the highest-numbered lane's word is the one stored.
- R6: A request is taken when req_valid_i is high and busy_o is low. busy_o rises in the next cycle and stays high until the final access. A request presented while busy_o is high is ignored and writes nothing.
- R7: done_o is high for exactly one cycle, the cycle after the final access, with busy_o low. lane_rdata_o is valid from that cycle on and holds until the next request is taken.
- R8: When a request is taken, lane_rdata_o is cleared. After a write, and for every lane not enabled in a read, the lane's rdata reads zero.
- R9: conflict_cnt_o grows by (bank cycles - 1) per request, wrapping at 2^16, and changes only while a request is being served.
- R10: On a 32x32 word array stored row-major, a 16-lane column read takes 16 cycles with a row stride of 32 and 1 cycle with a row stride of 33. A 16-lane row read with stride 33 also takes 1 cycle.
- R11: A request with no enabled lanes takes one cycle and then signals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read, for all lanes |
| lane_en_i | input | 16 | Per-lane enable |
| lane_addr_i | input | 160 | Per-lane word address, lane l in bits [10l+9:10l] |
| lane_wdata_i | input | 512 | Per-lane write word, lane l in bits [32l+31:32l] |
| busy_o | output | 1 | Request in flight |
| done_o | output | 1 | One-cycle completion pulse |
| lane_rdata_o | output | 512 | Per-lane read word, same packing as lane_wdata_i |
| conflict_cnt_o | output | 16 | Accumulated extra cycles caused by collisions |

## Verification
A new request and the last bank access of the request already in flight can land in the same cycle. The bench provokes this by raising a write on req_valid_i in the first serve cycle. For one-cycle requests that cycle is also the completion cycle. The bench then reads the poked word back and confirms it kept its old value. Separately, broadcast detection and collision serialization compete to decide the cycle count of the same request. This is judged by sweeping lane strides from 1 to 33 and mixing same-address reads and writes, with the expected cycle count computed from per-bank lane counts in the bench.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  localparam int unsigned NUM_LANES = 16;
  localparam int unsigned NUM_BANKS = 16;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WADDR_W   = 10;
  localparam int unsigned PROF_W    = 16;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_BCAST = 2'd2
  } serve_mode_e;
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ROW_W  = 6
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[row_i] <= wdata_i;
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned BANK_ID = 0
) (
  input  logic [LANES-1:0]        pend_i,
  input  logic [LANES*ADDR_W-1:0] lane_addr_i,
  input  logic [LANES*WORD_W-1:0] lane_wdata_i,
  output logic [LANES-1:0]        grant_o,
  output logic                    en_o,
  output logic [ADDR_W-BANK_W-1:0] row_o,
  output logic [WORD_W-1:0]       wdata_o
);
  localparam int unsigned ROW_W = ADDR_W - BANK_W;

  logic [LANES-1:0] hit;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pend_i[l] &&
               (lane_addr_i[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID));
    end
  end

  // lowest pending lane wins this bank
  assign grant_o = hit & (~hit + LANES'(1));
  assign en_o    = |hit;

  always_comb begin
    row_o   = '0;
    wdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (grant_o[l]) begin
        row_o   = row_o   | lane_addr_i[l*ADDR_W + BANK_W +: ROW_W];
        wdata_o = wdata_o | lane_wdata_i[l*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/sp_bcast_detect.sv
module sp_bcast_detect #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                    we_i,
  input  logic [LANES-1:0]        en_i,
  input  logic [LANES*ADDR_W-1:0] addr_i,
  output logic                    bcast_o
);
  logic              found;
  logic              same;
  logic [ADDR_W-1:0] ref_addr;

  always_comb begin
    found    = 1'b0;
    ref_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (en_i[l] && !found) begin
        ref_addr = addr_i[l*ADDR_W +: ADDR_W];
        found    = 1'b1;
      end
    end
    same = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (en_i[l] && (addr_i[l*ADDR_W +: ADDR_W] != ref_addr)) same = 1'b0;
    end
    bcast_o = found && same && !we_i;
  end
endmodule

// File: rtl/sp_conflict_arb.sv
module sp_conflict_arb
  import sp_arb_pkg::*;
#(
  parameter int unsigned LANES  = NUM_LANES,
  parameter int unsigned BANKS  = NUM_BANKS,
  parameter int unsigned WORD_W = sp_arb_pkg::WORD_W,
  parameter int unsigned ADDR_W = WADDR_W,
  parameter int unsigned PROF_W = sp_arb_pkg::PROF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic [LANES*ADDR_W-1:0] lane_addr_i,
  input  logic [LANES*WORD_W-1:0] lane_wdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANES*WORD_W-1:0] lane_rdata_o,
  output logic [PROF_W-1:0]       conflict_cnt_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;

  serve_mode_e             mode_q;
  logic                    we_q;
  logic                    first_q;
  logic                    done_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*WORD_W-1:0] wdata_q;
  logic [LANES*WORD_W-1:0] rdata_q;
  logic [PROF_W-1:0]       cnt_q;

  logic                    accept;
  logic                    bcast;
  logic [LANES-1:0]        grant_bank [BANKS];
  logic [LANES-1:0]        grant_any;
  logic [LANES-1:0]        served;
  logic [LANES-1:0]        pend_nxt;
  logic [WORD_W-1:0]       bank_rd [BANKS];
  logic [WORD_W-1:0]       lane_rd [LANES];

  assign accept = req_valid_i && (mode_q == MODE_IDLE);

  sp_bcast_detect #(
    .LANES (LANES),
    .ADDR_W(ADDR_W)
  ) u_bcast (
    .we_i   (req_we_i),
    .en_i   (lane_en_i),
    .addr_i (lane_addr_i),
    .bcast_o(bcast)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              en;
    logic [ROW_W-1:0]  row;
    logic [WORD_W-1:0] wd;

    sp_bank_pick #(
      .LANES  (LANES),
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .WORD_W (WORD_W),
      .BANK_ID(b)
    ) u_pick (
      .pend_i      (pend_q),
      .lane_addr_i (addr_q),
      .lane_wdata_i(wdata_q),
      .grant_o     (grant_bank[b]),
      .en_o        (en),
      .row_o       (row),
      .wdata_o     (wd)
    );

    sp_bank #(
      .WORD_W(WORD_W),
      .ROW_W (ROW_W)
    ) u_bank (
      .clk_i  (clk_i),
      .en_i   (en),
      .we_i   (we_q),
      .row_i  (row),
      .wdata_i(wd),
      .rdata_o(bank_rd[b])
    );
  end

  always_comb begin
    grant_any = '0;
    for (int b = 0; b < BANKS; b++) grant_any = grant_any | grant_bank[b];
  end

  // broadcast: all pending lanes share one word, served together
  assign served   = (mode_q == MODE_BCAST) ? pend_q : grant_any;
  assign pend_nxt = pend_q & ~served;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_rd[l] = bank_rd[addr_q[l*ADDR_W +: BANK_W]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_IDLE;
      we_q    <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q  <= bcast ? MODE_BCAST : MODE_SPLIT;
        we_q    <= req_we_i;
        first_q <= 1'b1;
        pend_q  <= lane_en_i;
        addr_q  <= lane_addr_i;
        wdata_q <= lane_wdata_i;
        rdata_q <= '0;
      end else if (mode_q != MODE_IDLE) begin
        pend_q  <= pend_nxt;
        first_q <= 1'b0;
        if (!first_q) cnt_q <= cnt_q + PROF_W'(1);
        for (int l = 0; l < LANES; l++) begin
          if (served[l] && !we_q) rdata_q[l*WORD_W +: WORD_W] <= lane_rd[l];
        end
        if (pend_nxt == '0) begin
          mode_q <= MODE_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o         = (mode_q != MODE_IDLE);
  assign done_o         = done_q;
  assign lane_rdata_o   = rdata_q;
  assign conflict_cnt_o = cnt_q;
endmodule

// File: rtl/sp_conflict_arb_chk.sv
module sp_conflict_arb_chk #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned PROF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [PROF_W-1:0] conflict_cnt_o,
  input logic [LANES-1:0]  pend_i,
  input logic [LANES-1:0]  served_i
);
  localparam int unsigned RUN_W = $clog2(LANES) + 2;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (!busy_o) run_q <= '0;
    else              run_q <= run_q + RUN_W'(1);
  end

  a_r6_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_cnt_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(conflict_cnt_o) |-> $past(busy_o) && $past(busy_o, 2));

  a_r3_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (pend_i != '0) |-> served_i != '0);

  a_r3_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(LANES));
endmodule

bind sp_conflict_arb sp_conflict_arb_chk #(
  .LANES (LANES),
  .PROF_W(PROF_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .conflict_cnt_o(conflict_cnt_o),
  .pend_i        (pend_q),
  .served_i      (served)
);

// File: tb/sp_conflict_arb_tb.sv
module sp_conflict_arb_tb;
  localparam int LANES = 16;
  localparam int WW    = 32;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_we = 1'b0;
  logic [LANES-1:0]     lane_en = '0;
  logic [LANES*AW-1:0]  lane_addr = '0;
  logic [LANES*WW-1:0]  lane_wdata = '0;
  logic                 busy;
  logic                 done;
  logic [LANES*WW-1:0]  lane_rdata;
  logic [15:0]          cnt;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_cnt = '0;
  logic [WW-1:0] model [DEPTH];
  logic [AW-1:0] req_a [LANES];
  logic [WW-1:0] req_d [LANES];

  always #5 clk = ~clk;

  sp_conflict_arb u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .req_we_i      (req_we),
    .lane_en_i     (lane_en),
    .lane_addr_i   (lane_addr),
    .lane_wdata_i  (lane_wdata),
    .busy_o        (busy),
    .done_o        (done),
    .lane_rdata_o  (lane_rdata),
    .conflict_cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic we, input logic [LANES-1:0] en);
    int per_bank [16];
    int mx = 0;
    bit same = 1'b1;
    bit seen = 1'b0;
    logic [AW-1:0] r = '0;
    for (int b = 0; b < 16; b++) per_bank[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      if (en[l]) begin
        if (!seen) begin r = req_a[l]; seen = 1'b1; end
        else if (req_a[l] != r) same = 1'b0;
        per_bank[req_a[l][3:0]]++;
      end
    end
    if (!seen) return 1;
    if (!we && same) return 1;
    for (int b = 0; b < 16; b++) if (per_bank[b] > mx) mx = per_bank[b];
    return mx;
  endfunction

  // issue one request, wait for done, check cycles, data, counter
  task automatic run_req(input logic we, input logic [LANES-1:0] en,
                         input bit poke, input logic [AW-1:0] poke_addr,
                         input string tag, output int cyc);
    int ecyc;
    logic [LANES*WW-1:0] exp_rd;
    logic [LANES*WW-1:0] held;
    bit ok;
    ecyc = exp_cycles(we, en);
    @(negedge clk);
    req_we  = we;
    lane_en = en;
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l*AW +: AW]  = req_a[l];
      lane_wdata[l*WW +: WW] = req_d[l];
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 200) begin
      cyc++;
      if (poke && cyc == 1) begin
        req_we     = 1'b1;
        lane_en    = 16'h0001;
        lane_addr[0 +: AW] = poke_addr;
        lane_wdata[0 +: WW] = 32'hDEAD_BEEF;
        req_valid  = 1'b1;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    if (we) begin
      for (int l = 0; l < LANES; l++) if (en[l]) model[req_a[l]] = req_d[l];
    end
    for (int l = 0; l < LANES; l++)
      exp_rd[l*WW +: WW] = (!we && en[l]) ? model[req_a[l]] : '0;
    exp_cnt = exp_cnt + 16'(ecyc - 1);
    chk(cyc == ecyc, {tag, " cycles"}, 64'(cyc), 64'(ecyc));
    chk(done == 1'b1, "R7 done pulse high", 64'(done), 64'd1);
    ok = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (lane_rdata[l*WW +: WW] !== exp_rd[l*WW +: WW]) begin
        if (ok) $display("FAIL R8 lane %0d rdata actual=%0h expected=%0h",
                         l, lane_rdata[l*WW +: WW], exp_rd[l*WW +: WW]);
        ok = 1'b0;
      end
    end
    checks++;
    if (!ok) fails++;
    chk(cnt == exp_cnt, "R9 conflict counter", 64'(cnt), 64'(exp_cnt));
    held = lane_rdata;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
    chk(lane_rdata == held, "R7 rdata held", 64'(lane_rdata[63:0]), 64'(held[63:0]));
  endtask

  function automatic logic [WW-1:0] pat(input int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R6 reset busy", 64'(busy), 0);
    chk(done == 1'b0, "R7 reset done", 64'(done), 0);
    chk(cnt == '0, "R9 reset counter", 64'(cnt), 0);
    chk(lane_rdata == '0, "R8 reset rdata", 64'(lane_rdata[63:0]), 0);
    rst_n = 1'b1;

    // R2: fill with 16 consecutive words per request
    for (int k = 0; k < DEPTH / LANES; k++) begin
      for (int l = 0; l < LANES; l++) begin
        req_a[l] = AW'(k * LANES + l);
        req_d[l] = pat(k * LANES + l);
      end
      run_req(1'b1, '1, 1'b0, '0, "R2 fill", c);
    end

    // R1: addresses 5 and 21 share bank 5; 5 and 22 do not
    for (int l = 0; l < LANES; l++) begin req_a[l] = '0; req_d[l] = '0; end
    req_a[0] = 10'd5; req_a[1] = 10'd21;
    run_req(1'b0, 16'h0003, 1'b0, '0, "R1 same low bits", c);
    req_a[1] = 10'd22;
    run_req(1'b0, 16'h0003, 1'b0, '0, "R1 different low bits", c);

    // R3/R10: stride sweep over column reads
    for (int s = 1; s <= 33; s++) begin
      for (int l = 0; l < LANES; l++) req_a[l] = AW'((3 + l * s) % DEPTH);
      run_req(1'b0, '1, 1'b0, '0, "R3 stride sweep", c);
      if (s == 32) chk(c == 16, "R10 stride 32 column", 64'(c), 64'd16);
      if (s == 33) chk(c == 1, "R10 stride 33 column", 64'(c), 64'd1);
    end
    for (int l = 0; l < LANES; l++) req_a[l] = AW'(5 * 33 + l);
    run_req(1'b0, '1, 1'b0, '0, "R10 stride 33 row", c);
    chk(c == 1, "R10 stride 33 row", 64'(c), 64'd1);

    // R4: broadcast reads, full and sparse
    for (int l = 0; l < LANES; l++) req_a[l] = 10'd77;
    run_req(1'b0, '1, 1'b0, '0, "R4 broadcast full", c);
    run_req(1'b0, 16'hA5C3, 1'b0, '0, "R4 broadcast sparse", c);

    // R5: all lanes write one address; highest lane wins
    for (int l = 0; l < LANES; l++) begin req_a[l] = 10'd200; req_d[l] = 32'h1000 + 32'(l); end
    run_req(1'b1, '1, 1'b0, '0, "R5 same-address write", c);
    run_req(1'b0, 16'h0001, 1'b0, '0, "R5 read back", c);
    chk(lane_rdata[0 +: WW] == 32'h100F, "R5 highest lane wins",
        64'(lane_rdata[0 +: WW]), 64'h100F);
    req_d[15] = '0;
    run_req(1'b1, 16'h7FFF, 1'b0, '0, "R5 partial same-address write", c);

    // R11: empty request
    run_req(1'b0, '0, 1'b0, '0, "R11 empty read", c);
    run_req(1'b1, '0, 1'b0, '0, "R11 empty write", c);

    // R6: request presented while busy is ignored
    for (int l = 0; l < LANES; l++) req_a[l] = AW'(l * 16);
    run_req(1'b0, '1, 1'b1, 10'd300, "R6 poke during conflict", c);
    for (int l = 0; l < LANES; l++) req_a[l] = AW'(l);
    run_req(1'b0, '1, 1'b1, 10'd301, "R6 poke during single cycle", c);
    for (int l = 0; l < LANES; l++) req_a[l] = (l < 8) ? 10'd300 : 10'd301;
    run_req(1'b0, '1, 1'b0, '0, "R6 poked words unchanged", c);
    chk(lane_rdata[0 +: WW] == pat(300), "R6 ignored write 300",
        64'(lane_rdata[0 +: WW]), 64'(pat(300)));
    chk(lane_rdata[8*WW +: WW] == pat(301), "R6 ignored write 301",
        64'(lane_rdata[8*WW +: WW]), 64'(pat(301)));

    // mixed patterns with a small address pool to force collisions
    for (int n = 0; n < 300; n++) begin
      logic [LANES-1:0] en;
      logic we;
      en = LANES'($urandom);
      we = 1'($urandom);
      for (int l = 0; l < LANES; l++) begin
        req_a[l] = (n % 3 == 0) ? AW'($urandom % 24) : AW'($urandom);
        req_d[l] = $urandom;
      end
      run_req(we, en, 1'b0, '0, "R3 mixed", c);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule